// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Update

This block is the combinational datapath core of a classic 8-bit accumulator processor. Each cycle the sequencer presents the accumulator, the X index register, an operand byte, the current status byte and an operation code. In the same cycle the block returns three things: the result byte, a code that names where that byte must be written (accumulator, X, memory or nowhere), and the new status byte.

The operations are:
- add with carry and subtract with borrow
- compare against A or against X
- the three bitwise logic operations
- bit test
- loads into A or X
- increment and decrement of the operand
- shifts and rotates in both directions, on either the accumulator or the operand
- a combined operation that ANDs A with X, subtracts the operand and writes the result to X

Arithmetic is binary only. Register storage, instruction sequencing and bus access belong to the surrounding processor.

The status byte uses these positions: C is bit 0, Z is bit 1, V is bit 6 and N is bit 7. Bits 2 to 5 are control bits that this block never changes.

Top module: `alu8_core`

## Requirements
- R1: The operation codes are 0 add, 1 subtract, 2 compare with A, 3 compare with X, 4 AND, 5 OR, 6 XOR, 7 bit test, 8 increment, 9 decrement, 10 shift left, 11 shift right, 12 rotate left, 13 rotate right, 14 AND-then-subtract, 15 load A and 16 load X. The destination codes are 0 none, 1 accumulator, 2 X and 3 memory.
- R2: Add forms A + M + C. The result goes to the accumulator. C takes bit 8 of the 9-bit sum. V is set when A and M share a sign and the result's sign differs from A. Z and N follow the result.
- R3: Subtract forms A − M − (1 − C). The result goes to the accumulator. C is set when no borrow occurs. V is set when A's sign differs from both M and the result. Z and N follow the result.
- R4: Compare computes A − M (code 2) or X − M (code 3). Z and N come from the low byte of the difference and C is set when there is no borrow. V is unchanged, the destination is none and the result byte is the low byte of the difference.
- R5: AND, OR, XOR, load A and load X change only Z (set when the result is zero) and N (result bit 7). Loads pass M through. The destination is X for load X and the accumulator for the rest.
- R6: Bit test sets Z when A AND M is zero, copies M bit 7 into N and M bit 6 into V, gives A AND M as the result and has destination none.
- R7: Increment and decrement act on M modulo 256, update only Z and N, and have destination memory.
- R8: Shifts act on A when shift_acc_i is 1 (destination accumulator) and on M otherwise (destination memory). Shift left moves the old bit 7 into C. Shift right moves the old bit 0 into C and always clears N. In both cases Z follows the result.
- R9: Rotate left moves the old C into bit 0 and the old bit 7 into C. Rotate right moves the old C into bit 7 and the old bit 0 into C. Z and N follow the result and the source select is the same as in R8.
- R10: Code 14 computes (A AND X) − M, sends it to X, sets Z, N and C as a compare does, and leaves V unchanged.
- R11: Status bits 2 to 5 always pass through unchanged. Any flag an operation does not name also passes through. X affects no operation other than codes 3 and 14.
- R12: Codes 17 to 31 give result 0 and destination none, and leave the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code (R1) |
| acc_i | input | 8 | Accumulator value |
| xr_i | input | 8 | X register value |
| opnd_i | input | 8 | Operand byte M |
| stat_i | input | 8 | Incoming status byte |
| shift_acc_i | input | 1 | Shift/rotate source: 1 = accumulator, 0 = operand |
| result_o | output | 8 | Result byte |
| dest_o | output | 2 | Destination code |
| stat_o | output | 8 | Updated status byte |

## Verification
The hardest cases to reach are the signed-overflow boundaries of subtract with an incoming borrow, where the carry-in flips V and C on exactly one operand value. These cases are narrow and easy to miss with hand-picked stimulus. The bench therefore sweeps every operand pair with both carry-in values for every operation. It derives each status input from the operands so that the pass-through bits and V also vary. A hand-computed table then pins down the named boundary values.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OPW = 5;
  localparam int STW = 8;
  localparam int FC  = 0;
  localparam int FZ  = 1;
  localparam int FV  = 6;
  localparam int FN  = 7;

  typedef enum logic [OPW-1:0] {
    OP_ADC    = 5'd0,
    OP_SBC    = 5'd1,
    OP_CMPA   = 5'd2,
    OP_CMPX   = 5'd3,
    OP_AND    = 5'd4,
    OP_OR     = 5'd5,
    OP_XOR    = 5'd6,
    OP_BIT    = 5'd7,
    OP_INC    = 5'd8,
    OP_DEC    = 5'd9,
    OP_SHL    = 5'd10,
    OP_SHR    = 5'd11,
    OP_ROL    = 5'd12,
    OP_ROR    = 5'd13,
    OP_ANDSUB = 5'd14,
    OP_LDA    = 5'd15,
    OP_LDX    = 5'd16
  } op_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_ACC  = 2'd1,
    DST_XR   = 2'd2,
    DST_MEM  = 2'd3
  } dst_e;

  function automatic logic uses_adder(input logic [OPW-1:0] op);
    return (op == OP_ADC) || (op == OP_SBC) || (op == OP_CMPA) ||
           (op == OP_CMPX) || (op == OP_ANDSUB);
  endfunction

  function automatic logic uses_shifter(input logic [OPW-1:0] op);
    return (op == OP_SHL) || (op == OP_SHR) || (op == OP_ROL) || (op == OP_ROR);
  endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   acc_i,
  input  logic [W-1:0]   xr_i,
  input  logic [W-1:0]   opnd_i,
  input  logic           cin_i,
  output logic [W-1:0]   sum_o,
  output logic           cout_o,
  output logic           ovf_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] lhs;
  logic [W-1:0] rhs;
  logic         c0;
  logic [W:0]   full;

  // One adder serves every add/subtract form: subtraction is lhs + ~M + c0,
  // so bit W is already the no-borrow flag.
  always_comb begin
    lhs = acc_i;
    rhs = ~opnd_i;
    c0  = 1'b1;
    case (op_e'(op_i))
      OP_ADC:    begin rhs = opnd_i; c0 = cin_i; end
      OP_SBC:    c0 = cin_i;
      OP_CMPX:   lhs = xr_i;
      OP_ANDSUB: lhs = acc_i & xr_i;
      default:   ;
    endcase
    full = {1'b0, lhs} + {1'b0, rhs} + {{W{1'b0}}, c0};
  end

  assign sum_o  = full[MSB:0];
  assign cout_o = full[W];
  assign ovf_o  = (lhs[MSB] == rhs[MSB]) && (full[MSB] != lhs[MSB]);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   acc_i,
  input  logic [W-1:0]   opnd_i,
  output logic [W-1:0]   res_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    case (op_e'(op_i))
      OP_AND, OP_BIT: res_o = acc_i & opnd_i;
      OP_OR:          res_o = acc_i | opnd_i;
      OP_XOR:         res_o = acc_i ^ opnd_i;
      OP_INC:         res_o = opnd_i + ONE;
      OP_DEC:         res_o = opnd_i - ONE;
      OP_LDA, OP_LDX: res_o = opnd_i;
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   acc_i,
  input  logic [W-1:0]   opnd_i,
  input  logic           use_acc_i,
  input  logic           cin_i,
  output logic [W-1:0]   res_o,
  output logic           cout_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] src;
  assign src = use_acc_i ? acc_i : opnd_i;

  always_comb begin
    res_o  = src;
    cout_o = cin_i;
    case (op_e'(op_i))
      OP_SHL: begin res_o = {src[MSB-1:0], 1'b0};  cout_o = src[MSB]; end
      OP_SHR: begin res_o = {1'b0, src[MSB:1]};    cout_o = src[0];   end
      OP_ROL: begin res_o = {src[MSB-1:0], cin_i}; cout_o = src[MSB]; end
      OP_ROR: begin res_o = {cin_i, src[MSB:1]};   cout_o = src[0];   end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OPW-1:0] op_i,
  input  logic [STW-1:0] stat_i,
  input  logic [W-1:0]   res_i,
  input  logic           add_c_i,
  input  logic           add_v_i,
  input  logic           sh_c_i,
  input  logic [1:0]     m_top_i,
  input  logic           use_acc_i,
  output logic [STW-1:0] stat_o,
  output logic [1:0]     dest_o
);
  localparam int MSB = W - 1;

  logic is_zero;
  assign is_zero = (res_i == '0);

  always_comb begin
    stat_o = stat_i;
    dest_o = DST_NONE;
    case (op_e'(op_i))
      OP_ADC, OP_SBC: begin
        stat_o[FC] = add_c_i;   stat_o[FV] = add_v_i;
        stat_o[FZ] = is_zero;   stat_o[FN] = res_i[MSB];
        dest_o     = DST_ACC;
      end
      OP_CMPA, OP_CMPX, OP_ANDSUB: begin
        stat_o[FC] = add_c_i;
        stat_o[FZ] = is_zero;   stat_o[FN] = res_i[MSB];
        dest_o     = (op_i == OP_ANDSUB) ? DST_XR : DST_NONE;
      end
      OP_AND, OP_OR, OP_XOR, OP_LDA, OP_LDX: begin
        stat_o[FZ] = is_zero;   stat_o[FN] = res_i[MSB];
        dest_o     = (op_i == OP_LDX) ? DST_XR : DST_ACC;
      end
      OP_BIT: begin
        stat_o[FZ] = is_zero;
        stat_o[FN] = m_top_i[1];
        stat_o[FV] = m_top_i[0];
      end
      OP_INC, OP_DEC: begin
        stat_o[FZ] = is_zero;   stat_o[FN] = res_i[MSB];
        dest_o     = DST_MEM;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        stat_o[FC] = sh_c_i;
        stat_o[FZ] = is_zero;   stat_o[FN] = res_i[MSB];
        dest_o     = use_acc_i ? DST_ACC : DST_MEM;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [4:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] xr_i,
  input  logic [W-1:0] opnd_i,
  input  logic [7:0]   stat_i,
  input  logic         shift_acc_i,
  output logic [W-1:0] result_o,
  output logic [1:0]   dest_o,
  output logic [7:0]   stat_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] add_sum;
  logic         add_carry;
  logic         add_ovf;
  logic [W-1:0] sh_res;
  logic         sh_carry;
  logic [W-1:0] lg_res;

  alu8_arith #(.W(W)) u_arith (
    .op_i(op_i), .acc_i(acc_i), .xr_i(xr_i), .opnd_i(opnd_i),
    .cin_i(stat_i[FC]), .sum_o(add_sum), .cout_o(add_carry), .ovf_o(add_ovf)
  );

  alu8_shift #(.W(W)) u_shift (
    .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i), .use_acc_i(shift_acc_i),
    .cin_i(stat_i[FC]), .res_o(sh_res), .cout_o(sh_carry)
  );

  alu8_logic #(.W(W)) u_logic (
    .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i), .res_o(lg_res)
  );

  always_comb begin
    if (uses_adder(op_i))        result_o = add_sum;
    else if (uses_shifter(op_i)) result_o = sh_res;
    else                         result_o = lg_res;
  end

  alu8_flags #(.W(W)) u_flags (
    .op_i(op_i), .stat_i(stat_i), .res_i(result_o),
    .add_c_i(add_carry), .add_v_i(add_ovf), .sh_c_i(sh_carry),
    .m_top_i(opnd_i[MSB -: 2]), .use_acc_i(shift_acc_i),
    .stat_o(stat_o), .dest_o(dest_o)
  );
endmodule

// File: rtl/alu8_checker.sv
module alu8_checker
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic [4:0]   op_i,
  input logic [W-1:0] opnd_i,
  input logic [7:0]   stat_i,
  input logic [W-1:0] result_o,
  input logic [1:0]   dest_o,
  input logic [7:0]   stat_o,
  input logic         add_carry,
  input logic         sh_carry
);
  localparam int MSB = W - 1;

  logic known;
  assign known = !$isunknown({op_i, opnd_i, stat_i, result_o, dest_o, stat_o});

  always_comb begin
    if (known) begin
      p_ctrl_bits_hold_r11: assert (stat_o[5:2] == stat_i[5:2]);
      if (op_i == OP_ADC || op_i == OP_SBC)
        p_carry_from_adder_r2: assert (stat_o[FC] == add_carry);
      if (op_i == OP_CMPA || op_i == OP_CMPX)
        p_compare_keeps_v_r4: assert (stat_o[FV] == stat_i[FV] && dest_o == DST_NONE);
      if (op_i == OP_BIT)
        p_bit_copies_nv_r6: assert (stat_o[FN] == opnd_i[MSB] && stat_o[FV] == opnd_i[MSB-1]);
      if (op_i == OP_SHR)
        p_shr_clears_n_r8: assert (!stat_o[FN] && stat_o[FC] == sh_carry);
      if (op_i == OP_ANDSUB)
        p_andsub_to_x_r10: assert (dest_o == DST_XR && stat_o[FV] == stat_i[FV]);
      if (op_i <= 5'd16 && op_i != OP_BIT)
        p_zero_tracks_result_r5: assert (stat_o[FZ] == (result_o == '0));
      if (op_i > 5'd16)
        p_unknown_op_idle_r12: assert (stat_o == stat_i && dest_o == DST_NONE && result_o == '0);
    end
  end
endmodule

bind alu8_core alu8_checker #(.W(W)) u_chk (
  .op_i(op_i), .opnd_i(opnd_i), .stat_i(stat_i), .result_o(result_o),
  .dest_o(dest_o), .stat_o(stat_o), .add_carry(add_carry), .sh_carry(sh_carry)
);

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0] op;
  logic [7:0] a, x, m, st;
  logic       sacc;
  logic [7:0] res, so;
  logic [1:0] dst;

  alu8_core dut (
    .op_i(op), .acc_i(a), .xr_i(x), .opnd_i(m), .stat_i(st), .shift_acc_i(sacc),
    .result_o(res), .dest_o(dst), .stat_o(so)
  );

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int zn(input int s, input int v);
    return (s & 'h7D) | ((v == 0) ? 'h02 : 0) | (v & 'h80);
  endfunction

  // Independent reference: integer arithmetic, signs taken from XOR terms.
  task automatic ref_model(input int o, input int ia, input int ix, input int im,
                           input int is, input int ish,
                           output int r, output int s, output int d);
    int c, t, src;
    c = is & 1; s = is; r = 0; d = 0;
    src = ish ? ia : im;
    case (o)
      0: begin t = ia + im + c; r = t & 255; d = 1;
               s = (zn(is, r) & 'hBE) | (t > 255 ? 1 : 0)
                   | ((((ia ^ r) & (im ^ r) & 'h80) != 0) ? 'h40 : 0); end
      1: begin t = ia - im - (1 - c); r = t & 255; d = 1;
               s = (zn(is, r) & 'hBE) | (t >= 0 ? 1 : 0)
                   | ((((ia ^ im) & (ia ^ r) & 'h80) != 0) ? 'h40 : 0); end
      2, 3, 14: begin
               t = (o == 2) ? ia - im : (o == 3) ? ix - im : (ia & ix) - im;
               r = t & 255; d = (o == 14) ? 2 : 0;
               s = (zn(is, r) & 'hFE) | (t >= 0 ? 1 : 0); end
      4: begin r = ia & im; s = zn(is, r); d = 1; end
      5: begin r = ia | im; s = zn(is, r); d = 1; end
      6: begin r = ia ^ im; s = zn(is, r); d = 1; end
      7: begin r = ia & im; d = 0;
               s = (is & 'h3D) | (r == 0 ? 2 : 0) | (im & 'hC0); end
      8: begin r = (im + 1) & 255; s = zn(is, r); d = 3; end
      9: begin r = (im + 255) & 255; s = zn(is, r); d = 3; end
      10: begin r = (src * 2) & 255; s = (zn(is, r) & 'hFE) | (src >> 7); end
      11: begin r = src / 2; s = (zn(is, r) & 'hFE) | (src & 1); end
      12: begin r = ((src * 2) & 255) | c; s = (zn(is, r) & 'hFE) | (src >> 7); end
      13: begin r = (src >> 1) | (c * 128); s = (zn(is, r) & 'hFE) | (src & 1); end
      15: begin r = im; s = zn(is, r); d = 1; end
      16: begin r = im; s = zn(is, r); d = 2; end
      default: ;
    endcase
    if (o >= 10 && o <= 13) d = ish ? 1 : 3;
  endtask

  function automatic string tag_of(input int o);
    case (o)
      0: return "R2";  1: return "R3";  2, 3: return "R4";
      4, 5, 6, 15, 16: return "R5";  7: return "R6";  8, 9: return "R7";
      10, 11: return "R8";  12, 13: return "R9";  14: return "R10";
      default: return "R12";
    endcase
  endfunction

  // op, a, x, m, st, sacc, exp result, exp status, exp dest
  localparam int NV = 22;
  localparam logic [55:0] VEC [NV] = '{
    {5'd0,  8'h50, 8'h00, 8'h50, 8'h00, 1'b0, 8'hA0, 8'hC0, 2'd1},
    {5'd0,  8'hFF, 8'h00, 8'h01, 8'h00, 1'b0, 8'h00, 8'h03, 2'd1},
    {5'd0,  8'h7F, 8'h00, 8'h00, 8'h01, 1'b0, 8'h80, 8'hC0, 2'd1},
    {5'd1,  8'h50, 8'h00, 8'hF0, 8'h01, 1'b0, 8'h60, 8'h00, 2'd1},
    {5'd1,  8'h80, 8'h00, 8'h01, 8'h01, 1'b0, 8'h7F, 8'h41, 2'd1},
    {5'd1,  8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'hFF, 8'h80, 2'd1},
    {5'd2,  8'h40, 8'h00, 8'h40, 8'h40, 1'b0, 8'h00, 8'h43, 2'd0},
    {5'd3,  8'h00, 8'h10, 8'h20, 8'h00, 1'b0, 8'hF0, 8'h80, 2'd0},
    {5'd4,  8'hF0, 8'h00, 8'h0F, 8'h81, 1'b0, 8'h00, 8'h03, 2'd1},
    {5'd7,  8'h01, 8'h00, 8'hC0, 8'h00, 1'b0, 8'h00, 8'hC2, 2'd0},
    {5'd8,  8'h00, 8'h00, 8'hFF, 8'h00, 1'b0, 8'h00, 8'h02, 2'd3},
    {5'd9,  8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'hFF, 8'h80, 2'd3},
    {5'd10, 8'h81, 8'h00, 8'h00, 8'h00, 1'b1, 8'h02, 8'h01, 2'd1},
    {5'd11, 8'hFF, 8'h00, 8'h01, 8'h80, 1'b0, 8'h00, 8'h03, 2'd3},
    {5'd12, 8'h80, 8'h00, 8'h00, 8'h01, 1'b1, 8'h01, 8'h01, 2'd1},
    {5'd13, 8'h00, 8'h00, 8'h01, 8'h01, 1'b0, 8'h80, 8'h81, 2'd3},
    {5'd14, 8'hFF, 8'h0F, 8'h10, 8'h40, 1'b0, 8'hFF, 8'hC0, 2'd2},
    {5'd16, 8'h00, 8'h00, 8'h00, 8'h3C, 1'b0, 8'h00, 8'h3E, 2'd2},
    {5'd6,  8'hFF, 8'h00, 8'h0F, 8'h00, 1'b0, 8'hF0, 8'h80, 2'd1},
    {5'd5,  8'h00, 8'h00, 8'h00, 8'h80, 1'b0, 8'h00, 8'h02, 2'd1},
    {5'd15, 8'h00, 8'h00, 8'h80, 8'h00, 1'b0, 8'h80, 8'h80, 2'd1},
    {5'd31, 8'h12, 8'h00, 8'h34, 8'hA5, 1'b0, 8'h00, 8'hA5, 2'd0}
  };

  initial begin
    op = 5'd31; a = '0; x = '0; m = '0; st = '0; sacc = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 idle outputs at start
    check(res == 8'h00 && dst == 2'd0 && so == 8'h00, "R12", "idle after reset",
          {res, so}, 16'h0000);

    // R1 table of hand-computed vectors
    for (int i = 0; i < NV; i++) begin
      op = VEC[i][55:51]; a = VEC[i][50:43]; x = VEC[i][42:35]; m = VEC[i][34:27];
      st = VEC[i][26:19]; sacc = VEC[i][18];
      #1;
      check(res == VEC[i][17:10] && so == VEC[i][9:2] && dst == VEC[i][1:0],
            tag_of(int'(VEC[i][55:51])), $sformatf("R1 vector %0d", i),
            {res, so, 6'd0, dst}, {VEC[i][17:2], 6'd0, VEC[i][1:0]});
    end

    // Exhaustive sweep per operation against the reference model
    for (int o = 0; o < 17; o++) begin
      int bad = 0;
      int fr = 0, fs = 0, fd = 0, er = 0, es = 0, ed = 0;
      for (int ia = 0; ia < 256; ia++) begin
        for (int im = 0; im < 256; im++) begin
          for (int c = 0; c < 2; c++) begin
            int r, s, d, ist, ix, ish;
            ix  = ia ^ 'h5A ^ im;
            ist = ((ia ^ (im * 3)) & 'hFE) | c;
            ish = im & 1;
            op = 5'(o); a = 8'(ia); x = 8'(ix); m = 8'(im); st = 8'(ist); sacc = ish[0];
            #1ps;
            ref_model(o, ia, ix & 255, im, ist & 255, ish, r, s, d);
            if (res != 8'(r) || so != 8'(s) || dst != 2'(d)) begin
              if (bad == 0) begin
                fr = res; fs = so; fd = dst; er = r; es = s; ed = d;
              end
              bad++;
            end
          end
        end
      end
      check(bad == 0, tag_of(o), $sformatf("sweep op %0d (res,stat,dest)", o),
            (fr << 16) | (fs << 8) | fd, (er << 16) | (es << 8) | ed);
    end

    // R11: X does not influence add
    op = 5'd0; a = 8'h3C; m = 8'h41; st = 8'h01; sacc = 1'b0; x = 8'h00;
    #1;
    begin
      logic [15:0] first;
      first = {res, so};
      x = 8'hFF;
      #1;
      check({res, so} == first, "R11", "X ignored by add", {res, so}, first);
    end
    // R11: control bits pass on every defined op
    begin
      int bad = 0;
      for (int o = 0; o < 32; o++) begin
        op = 5'(o); a = 8'h9E; m = 8'h63; x = 8'h27; st = 8'h3C; sacc = 1'b1;
        #1ps;
        if (so[5:2] != 4'hF) bad++;
      end
      check(bad == 0, "R11", "control bits held", bad, 0);
    end
    // R12: all undefined codes idle
    begin
      int bad = 0;
      for (int o = 17; o < 32; o++) begin
        op = 5'(o); st = 8'h5A; #1ps;
        if (res != 0 || dst != 0 || so != 8'h5A) bad++;
      end
      check(bad == 0, "R12", "undefined codes idle", bad, 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule